// File: doc/BRIEF.md
# QoS Identifier Control Register

This block is one hart's register for quality-of-service tagging. It holds two identifiers. The first is a resource-control ID, which shared caches and memory controllers use to apply capacity and bandwidth limits. The second is a monitoring-counter ID, which those controllers use to pick the usage counter to update. Both identifiers are driven on sideband outputs all the time, so every outgoing memory request carries the pair that is currently programmed.

The CSR instruction decoder presents read and write requests to the block. The block decides whether the access may proceed from three inputs: the current privilege level, the virtualization flag and the machine-level state-enable bit for this register. A denied access raises exactly one of two exception types: an illegal-instruction trap or a virtual-instruction trap. Trap handling and mode tracking stay outside the block.

Top module: `qos_id_csr`

## Requirements
- R1: After reset, both identifiers read as zero and both sideband outputs are zero.
- R2: A granted read returns the resource-control ID in bits [11:0] and the monitoring-counter ID in bits [27:16]. Every other bit reads as zero.
- R3: A granted write stores write-data bits [11:0] as the resource-control ID and bits [27:16] as the monitoring-counter ID. Writes to all other bits are ignored.
- R4: Machine mode (priv_mode = 3) is always granted, whatever the state-enable bit and the virtualization flag are set to.
- R5: Below machine mode, when the state-enable bit is clear, the access raises trap_illegal.
- R6: Below machine mode, when the state-enable bit is set and virtualization is on, the access raises trap_virtual.
- R7: With the state-enable bit set and virtualization off, supervisor mode (priv_mode = 1) is granted. User mode (0) and the reserved value (2) raise trap_illegal.
- R8: A denied access leaves both identifiers unchanged and returns zero read data.
- R9: The sideband outputs show the stored identifiers. After a granted write they change on the next rising clock edge and not before it.
- R10: A request whose address differs from the register's address raises no trap, returns zero and changes nothing.
- R11: Neither trap is asserted without a request, and the two traps are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | CSR access request valid this cycle |
| csr_addr | input | 12 | CSR address of the access |
| csr_we | input | 1 | Access is a write |
| csr_wdata | input | XLEN | Write data |
| priv_mode | input | 2 | Current privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| virt_on | input | 1 | Hart runs in virtualized mode |
| sen_bit | input | 1 | Machine state-enable bit for this register |
| csr_rdata | output | XLEN | Read data, zero unless the access is granted |
| trap_illegal | output | 1 | Access denied: illegal-instruction exception |
| trap_virtual | output | 1 | Access denied: virtual-instruction exception |
| tag_rcid | output | RC_W | Resource-control ID sent with outgoing requests |
| tag_mcid | output | MC_W | Monitoring-counter ID sent with outgoing requests |

## Verification
The access check is swept over every combination of privilege level, virtualization flag, state-enable bit and read/write. This separates the grant path from each of the two trap causes and from their priority order. Each access writes a distinct data word, and the held identifiers are checked afterwards. This shows whether a denied write has leaked into storage. Writing all ones exposes any reserved bit that gets stored by mistake. Accesses to a foreign address check that address decode alone suppresses traps and writes.

// File: rtl/qos_csr_pkg.sv
package qos_csr_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      ACC_NONE    = 2'd0,
      ACC_GRANT   = 2'd1,
      ACC_ILLEGAL = 2'd2,
      ACC_VIRT    = 2'd3
   } verdict_e;

endpackage

// File: rtl/qos_access_gate.sv
module qos_access_gate
   import qos_csr_pkg::*;
(
   input  logic     req,
   input  logic     hit,
   input  priv_e    priv,
   input  logic     virt,
   input  logic     sen,
   output verdict_e verdict
);

   // Priority: machine mode, then state-enable, then virtualization, then privilege.
   always_comb begin
      if (!(req && hit))        verdict = ACC_NONE;
      else if (priv == PRIV_M)  verdict = ACC_GRANT;
      else if (!sen)            verdict = ACC_ILLEGAL;
      else if (virt)            verdict = ACC_VIRT;
      else if (priv == PRIV_S)  verdict = ACC_GRANT;
      else                      verdict = ACC_ILLEGAL;
   end

endmodule

// File: rtl/qos_id_field.sv
module qos_id_field #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] value
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value <= '0;
      else if (wr_en) value <= wdata;
   end

endmodule

// File: rtl/qos_read_pack.sv
module qos_read_pack #(
   parameter int XLEN   = 32,
   parameter int RC_W   = 12,
   parameter int MC_W   = 12,
   parameter int MC_LSB = 16
) (
   input  logic            en,
   input  logic [RC_W-1:0] rc,
   input  logic [MC_W-1:0] mc,
   output logic [XLEN-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (en) begin
         rdata[RC_W-1:0]       = rc;
         rdata[MC_LSB +: MC_W] = mc;
      end
   end

endmodule

// File: rtl/qos_id_csr.sv
module qos_id_csr
   import qos_csr_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter logic [11:0] CSR_ADDR = 12'h181,
   parameter int          RC_W     = 12,
   parameter int          MC_W     = 12,
   parameter int          MC_LSB   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            csr_req,
   input  logic [11:0]     csr_addr,
   input  logic            csr_we,
   input  logic [XLEN-1:0] csr_wdata,
   input  logic [1:0]      priv_mode,
   input  logic            virt_on,
   input  logic            sen_bit,
   output logic [XLEN-1:0] csr_rdata,
   output logic            trap_illegal,
   output logic            trap_virtual,
   output logic [RC_W-1:0] tag_rcid,
   output logic [MC_W-1:0] tag_mcid
);

   localparam int MC_MSB = MC_LSB + MC_W - 1;

   // Elaboration-time parameter checks
   if (RC_W < 1 || MC_W < 1) begin : g_bad_width
      $error("qos_id_csr: ID widths must be positive");
   end
   if (RC_W > MC_LSB) begin : g_bad_overlap
      $error("qos_id_csr: fields overlap");
   end
   if (MC_MSB >= XLEN) begin : g_bad_xlen
      $error("qos_id_csr: monitoring field exceeds XLEN");
   end

   verdict_e verdict;
   logic     hit, wr_en, rd_en;
   logic     unused_wbits;

   assign hit   = (csr_addr == CSR_ADDR);
   assign unused_wbits = ^csr_wdata;

   qos_access_gate u_gate (
      .req     (csr_req),
      .hit     (hit),
      .priv    (priv_e'(priv_mode)),
      .virt    (virt_on),
      .sen     (sen_bit),
      .verdict (verdict)
   );

   assign rd_en        = (verdict == ACC_GRANT);
   assign wr_en        = rd_en && csr_we;
   assign trap_illegal = (verdict == ACC_ILLEGAL);
   assign trap_virtual = (verdict == ACC_VIRT);

   qos_id_field #(.W(RC_W)) u_rc (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (csr_wdata[RC_W-1:0]),
      .value (tag_rcid)
   );

   qos_id_field #(.W(MC_W)) u_mc (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (csr_wdata[MC_MSB:MC_LSB]),
      .value (tag_mcid)
   );

   qos_read_pack #(.XLEN(XLEN), .RC_W(RC_W), .MC_W(MC_W), .MC_LSB(MC_LSB)) u_rd (
      .en    (rd_en),
      .rc    (tag_rcid),
      .mc    (tag_mcid),
      .rdata (csr_rdata)
   );

endmodule

// File: rtl/qos_id_csr_chk.sv
module qos_id_csr_chk #(
   parameter int          XLEN     = 32,
   parameter logic [11:0] CSR_ADDR = 12'h181,
   parameter int          RC_W     = 12,
   parameter int          MC_W     = 12,
   parameter int          MC_LSB   = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            csr_req,
   input logic [11:0]     csr_addr,
   input logic            csr_we,
   input logic [XLEN-1:0] csr_wdata,
   input logic [1:0]      priv_mode,
   input logic            virt_on,
   input logic            sen_bit,
   input logic [XLEN-1:0] csr_rdata,
   input logic            trap_illegal,
   input logic            trap_virtual,
   input logic [RC_W-1:0] tag_rcid,
   input logic [MC_W-1:0] tag_mcid
);

   logic acc;
   assign acc = csr_req && (csr_addr == CSR_ADDR);

   a_r11_traps_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_illegal && trap_virtual));

   a_r11_no_trap_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_req |-> !trap_illegal && !trap_virtual);

   a_r4_machine_granted: assert property (@(posedge clk) disable iff (!rst_n)
      acc && priv_mode == 2'd3 |-> !trap_illegal && !trap_virtual);

   a_r5_sen_clear_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      acc && priv_mode != 2'd3 && !sen_bit |-> trap_illegal);

   a_r6_virt_fault: assert property (@(posedge clk) disable iff (!rst_n)
      acc && priv_mode != 2'd3 && sen_bit && virt_on |-> trap_virtual);

   a_r8_denied_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      csr_req && (trap_illegal || trap_virtual) |=> $stable(tag_rcid) && $stable(tag_mcid));

   a_r8_denied_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      trap_illegal || trap_virtual |-> csr_rdata == '0);

   a_r10_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      csr_req && csr_addr != CSR_ADDR |=> $stable(tag_rcid) && $stable(tag_mcid));

   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      acc && csr_we && priv_mode == 2'd3 |=>
         tag_rcid == $past(csr_wdata[RC_W-1:0]) && tag_mcid == $past(csr_wdata[MC_LSB +: MC_W]));

endmodule

bind qos_id_csr qos_id_csr_chk #(
   .XLEN(XLEN), .CSR_ADDR(CSR_ADDR), .RC_W(RC_W), .MC_W(MC_W), .MC_LSB(MC_LSB)
) u_chk (.*);

// File: tb/sim_qos_id_csr.sv
module sim_qos_id_csr;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        csr_req, csr_we, virt_on, sen_bit;
   logic [11:0] csr_addr;
   logic [31:0] csr_wdata, csr_rdata;
   logic [1:0]  priv_mode;
   logic        trap_illegal, trap_virtual;
   logic [11:0] tag_rcid, tag_mcid;

   int          n_checks = 0;
   int          n_errors = 0;
   logic [11:0] m_rc = '0, m_mc = '0;
   bit          done = 0;

   always #5 clk = ~clk;

   qos_id_csr u0 (
      .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_addr(csr_addr),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .priv_mode(priv_mode),
      .virt_on(virt_on), .sen_bit(sen_bit), .csr_rdata(csr_rdata),
      .trap_illegal(trap_illegal), .trap_virtual(trap_virtual),
      .tag_rcid(tag_rcid), .tag_mcid(tag_mcid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One access; expected values derived from the access rules
   task automatic access(input logic [1:0] pm, input logic v, input logic s,
                         input logic we, input logic [11:0] addr, input logic [31:0] wd);
      logic hit, grant, e_ill, e_vir;
      @(negedge clk);
      csr_req = 1'b1; priv_mode = pm; virt_on = v; sen_bit = s;
      csr_we = we; csr_addr = addr; csr_wdata = wd;
      hit = (addr == 12'h181);
      grant = 0; e_ill = 0; e_vir = 0;
      if (hit) begin
         if (pm == 2'd3)      grant = 1;
         else if (!s)         e_ill = 1;
         else if (v)          e_vir = 1;
         else if (pm == 2'd1) grant = 1;
         else                 e_ill = 1;
      end
      #1;
      chk(hit ? (pm == 3 ? "R4" : (!s ? "R5" : (v ? "R6" : "R7"))) : "R10",
          {30'd0, trap_illegal, trap_virtual}, {30'd0, e_ill, e_vir});
      chk(grant ? "R2" : "R8", csr_rdata,
          grant ? {4'd0, m_mc, 4'd0, m_rc} : 32'd0);
      chk("R9 before edge", {8'd0, tag_mcid, tag_rcid}, {8'd0, m_mc, m_rc});
      if (grant && we) begin
         m_rc = wd[11:0];
         m_mc = wd[27:16];
      end
      @(posedge clk); #1;
      csr_req = 1'b0;
      chk(grant && we ? "R3" : "R8", {8'd0, tag_mcid, tag_rcid}, {8'd0, m_mc, m_rc});
   endtask

   initial begin
      #1_000_000;
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int k = 0;
      rst_n = 1'b0; csr_req = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
      priv_mode = 2'd3; virt_on = 0; sen_bit = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 rcid", {20'd0, tag_rcid}, 32'd0);
      chk("R1 mcid", {20'd0, tag_mcid}, 32'd0);
      chk("R11 idle", {30'd0, trap_illegal, trap_virtual}, 32'd0);
      access(2'd3, 0, 0, 0, 12'h181, 32'd0);   // R1 readback

      // R3 reserved bits ignored, R2 layout
      access(2'd3, 1, 0, 1, 12'h181, 32'hFFFF_FFFF);
      access(2'd3, 0, 0, 0, 12'h181, 32'd0);
      access(2'd3, 0, 1, 1, 12'h181, 32'h0000_0000);

      // Full sweep of privilege, virt, state-enable, direction
      for (int pm = 0; pm < 4; pm++)
         for (int v = 0; v < 2; v++)
            for (int s = 0; s < 2; s++)
               for (int we = 0; we < 2; we++) begin
                  k++;
                  access(pm[1:0], v[0], s[0], we[0], 12'h181,
                         32'h5A3C_0000 ^ (k * 32'h0107_0301));
               end

      // R10 foreign addresses
      for (int a = 0; a < 4; a++)
         access(2'd3, 0, 1, 1, 12'h180 + 12'(a * 2), 32'h0ABC_0DEF);
      access(2'd3, 0, 0, 0, 12'h181, 32'd0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule